// File: doc/BRIEF.md
# External interrupt input conditioner

The conditioner turns a set of asynchronous external interrupt pins into clean request lines for a downstream interrupt sequencer. Each pin is first brought into the clock domain through a chain of synchronising flops. It then goes through an edge detector whose sensitivity is set per source by a 2-bit field of a configuration word. In edge modes a detected event sets a pending latch. The latch holds for as long as it takes the sequencer to get to the source, however long interrupts stay masked. The sequencer's acknowledge pulse, raised when it enters that source's service routine, clears the latch without any software action.

In level mode the synchronised pin, inverted so that low means active, drives the request line directly, with no latch in between. A combined wake output is the OR of every request and every edge event seen in the current cycle. A clock-gated low-power state can be left on it one cycle before the latch is visible. Masking, priority and vectoring are handled downstream and are not part of this block.

Top module: `ext_irq_cond`

## Requirements
- R1: While reset is applied and directly after it, every bit of `req_o` and `wake_o` is 0. The synchroniser and edge history reset to the idle-high level, so no spurious edge is seen.
- R2: A pin change is taken in through two flops. In level mode `req_o` follows on the 2nd rising clock edge after the pin changes. In edge modes it follows on the 3rd, and it is still 0 one edge earlier.
- R3: With sense field `01` (rising), a low-to-high pin transition sets the request and a high-to-low transition leaves it at 0.
- R4: With sense field `10` (falling), a high-to-low transition sets the request and a low-to-high transition does not set it again once it has been cleared.
- R5: With sense field `11` (both), either transition sets the request.
- R6: With sense field `00` (level), `req_o[i]` equals the inverted synchronised pin. It is not latched, and `ack_i[i]` has no effect on it.
- R7: In an edge mode a set request stays at 1 for any number of cycles until `ack_i[i]` is seen.
- R8: A one-cycle `ack_i[i]` pulse, with no new edge in that cycle, clears the edge request on the next clock edge.
- R9: If a new qualifying edge is detected in the same cycle as `ack_i[i]`, the request stays at 1.
- R10: While a source is in level mode its edge latch is cleared, so a request pending before the switch is gone when the source returns to an edge mode.
- R11: `wake_o` is 1 in any cycle where some request is 1 or some qualifying edge is being detected, so it rises one cycle before an edge request does.
- R12: The sense field of source i sits in bits `[2i+1:2i]` of `sense_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | N_SRC | Asynchronous external interrupt pins |
| sense_i | input | 2*N_SRC | Per-source sensitivity fields, 2 bits each |
| ack_i | input | N_SRC | Sequencer acknowledge on entry to a source's routine |
| req_o | output | N_SRC | Conditioned request per source |
| wake_o | output | 1 | Combined wake indication for the halted state |

## Verification
The checker assumes nothing about how `ack_i` relates to the pending state. It does assume that a change of a sense field is itself the cause of any drop of a request, so hold and clear properties are qualified by the mode staying the same. The pins are taken to be slow relative to the clock. The stimulus therefore holds every pin level for at least four cycles, pulses acknowledges for exactly one cycle, and changes sense fields only while the affected pin is idle. One acknowledge is placed on purpose in the cycle where the edge detector fires.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det
  import ext_irq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   lvl_i,
  input  sense_e sense_i,
  output logic   evt_o,
  output logic   edge_mode_o,
  output logic   lvl_act_o
);
  logic prev_q;
  logic rise, fall;

  // idle-high history: no fake falling edge out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (sense_i)
      SENSE_RISE: evt_o = rise;
      SENSE_FALL: evt_o = fall;
      SENSE_BOTH: evt_o = rise | fall;
      default:    evt_o = 1'b0;
    endcase
  end

  assign edge_mode_o = (sense_i != SENSE_LOW);
  assign lvl_act_o   = (sense_i == SENSE_LOW) & ~lvl_i;
endmodule

// File: rtl/irq_pend.sv
module irq_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_mode_i,
  input  logic evt_i,
  input  logic ack_i,
  output logic pend_o
);
  // a new event wins over a coincident acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pend_o <= 1'b0;
    else if (!edge_mode_i) pend_o <= 1'b0;
    else                   pend_o <= evt_i | (pend_o & ~ack_i);
  end
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
  import ext_irq_pkg::*;
#(
  parameter int N_SRC       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SRC-1:0]   pin_i,
  input  logic [2*N_SRC-1:0] sense_i,
  input  logic [N_SRC-1:0]   ack_i,
  output logic [N_SRC-1:0]   req_o,
  output logic               wake_o
);
  localparam int SenseW = 2;

  logic [N_SRC-1:0] sync_w;
  logic [N_SRC-1:0] evt_w;
  logic [N_SRC-1:0] edge_mode_w;
  logic [N_SRC-1:0] lvl_act_w;
  logic [N_SRC-1:0] pend_w;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    sense_e mode;
    assign mode = sense_e'(sense_i[SenseW*i +: SenseW]);

    irq_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(1'b1)
    ) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_i[i]),
      .q_o   (sync_w[i])
    );

    irq_edge_det u_edge (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lvl_i      (sync_w[i]),
      .sense_i    (mode),
      .evt_o      (evt_w[i]),
      .edge_mode_o(edge_mode_w[i]),
      .lvl_act_o  (lvl_act_w[i])
    );

    irq_pend u_pend (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .edge_mode_i(edge_mode_w[i]),
      .evt_i      (evt_w[i]),
      .ack_i      (ack_i[i]),
      .pend_o     (pend_w[i])
    );

    assign req_o[i] = edge_mode_w[i] ? pend_w[i] : lvl_act_w[i];
  end

  assign wake_o = |{req_o, evt_w};
endmodule

// File: rtl/ext_irq_cond_chk.sv
module ext_irq_cond_chk #(
  parameter int N_SRC = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [2*N_SRC-1:0] sense_i,
  input logic [N_SRC-1:0]   ack_i,
  input logic [N_SRC-1:0]   evt_i,
  input logic [N_SRC-1:0]   req_o,
  input logic               wake_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_chk
    logic [1:0] m;
    assign m = sense_i[2*i +: 2];

    // R7
    pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m != 2'b00 && req_o[i] && !ack_i[i]) |=> (req_o[i] || m == 2'b00));

    // R8
    ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m != 2'b00 && req_o[i] && ack_i[i] && !evt_i[i]) |=> (!req_o[i] || m != $past(m)));

    // R9
    ack_edge_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m != 2'b00 && evt_i[i]) |=> (req_o[i] || m == 2'b00));

    // R10
    level_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m == 2'b00) |=> (m == 2'b00 || !req_o[i]));

    // R3
    edge_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m != 2'b00 && $rose(req_o[i])) |-> $past(evt_i[i]));

    // R11
    wake_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m != 2'b00 && $rose(req_o[i])) |-> $past(wake_o));
  end
endmodule

bind ext_irq_cond ext_irq_cond_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sense_i(sense_i),
  .ack_i  (ack_i),
  .evt_i  (evt_w),
  .req_o  (req_o),
  .wake_o (wake_o)
);

// File: tb/ext_irq_cond_bench.sv
module ext_irq_cond_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin = '1;
  logic [N-1:0] ack = '0;
  logic [2*N-1:0] sense = '0;
  logic [N-1:0] req;
  logic         wake;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_cond #(.N_SRC(N), .SYNC_STAGES(2)) u_ext_irq_cond (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .pin_i  (pin),
    .sense_i(sense),
    .ack_i  (ack),
    .req_o  (req),
    .wake_o (wake)
  );

  typedef struct {
    int    at;
    int    src;
    bit    exp;
    bit    is_wake;
    string tag;
  } item_t;

  item_t sbq[$];
  int cyc = 0;
  int n_vec = 0;
  int n_err = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(int d, int src, bit e, bit w, string tag);
    item_t it;
    it.at = cyc + d; it.src = src; it.exp = e; it.is_wake = w; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wait_n(int n);
    repeat (n) tick();
  endtask

  task automatic pulse_ack(int src);
    ack[src] = 1'b1; tick(); ack[src] = 1'b0;
  endtask

  // monitor: compare every item due in this cycle
  always @(negedge clk) begin
    for (int k = sbq.size() - 1; k >= 0; k--) begin
      if (sbq[k].at == cyc) begin
        logic act;
        act = sbq[k].is_wake ? wake : req[sbq[k].src];
        n_vec++;
        if (act !== sbq[k].exp) begin
          n_err++;
          $display("FAIL %s: %s[%0d] cycle %0d actual %b expected %b", sbq[k].tag,
                   sbq[k].is_wake ? "wake" : "req", sbq[k].src, cyc, act, sbq[k].exp);
        end
        sbq.delete(k);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    // R1: quiet after reset
    for (int i = 0; i < N; i++) push(0, i, 1'b0, 1'b0, "R1");
    push(0, 0, 1'b0, 1'b1, "R1");
    wait_n(2);
    for (int i = 0; i < N; i++) push(0, i, 1'b0, 1'b0, "R1");

    // R12: src0 rise, src1 fall, src2 both, src3 level
    sense = 8'b00_11_10_01;
    wait_n(4);

    // R3: falling edge ignored in rise mode, no wake (R11)
    pin[0] = 1'b0;
    push(2, 0, 1'b0, 1'b1, "R11");
    push(3, 0, 1'b0, 1'b0, "R3");
    push(5, 0, 1'b0, 1'b0, "R3");
    wait_n(6);

    // R2/R3/R11: rising edge sets request after three edges, wake one earlier
    pin[0] = 1'b1;
    push(2, 0, 1'b0, 1'b0, "R2");
    push(2, 0, 1'b1, 1'b1, "R11");
    push(3, 0, 1'b1, 1'b0, "R3");
    wait_n(3);
    wait_n(20);
    push(0, 0, 1'b1, 1'b0, "R7");
    push(0, 0, 1'b1, 1'b1, "R11");
    pulse_ack(0);
    push(0, 0, 1'b0, 1'b0, "R8");
    wait_n(2);

    // R4: fall mode
    pin[1] = 1'b0;
    push(2, 1, 1'b0, 1'b0, "R2");
    push(3, 1, 1'b1, 1'b0, "R4");
    wait_n(4);
    pin[1] = 1'b1;
    wait_n(4);
    pulse_ack(1);
    push(0, 1, 1'b0, 1'b0, "R8");
    wait_n(5);
    push(0, 1, 1'b0, 1'b0, "R4");
    tick();

    // R5/R9: both mode, ack coincident with the rising edge event
    pin[2] = 1'b0;
    push(3, 2, 1'b1, 1'b0, "R5");
    wait_n(4);
    pin[2] = 1'b1;
    wait_n(2);
    pulse_ack(2);
    push(0, 2, 1'b1, 1'b0, "R9");
    wait_n(3);
    push(0, 2, 1'b1, 1'b0, "R9");
    pulse_ack(2);
    push(0, 2, 1'b0, 1'b0, "R8");
    wait_n(2);
    pin[2] = 1'b0;
    push(3, 2, 1'b1, 1'b0, "R5");
    wait_n(4);
    pulse_ack(2);
    push(0, 2, 1'b0, 1'b0, "R8");
    pin[2] = 1'b1;
    wait_n(4);
    pulse_ack(2);
    wait_n(2);

    // R6: level mode, unlatched, ack ignored
    pin[3] = 1'b0;
    push(1, 3, 1'b0, 1'b0, "R2");
    push(2, 3, 1'b1, 1'b0, "R6");
    wait_n(3);
    pulse_ack(3);
    push(0, 3, 1'b1, 1'b0, "R6");
    push(1, 3, 1'b1, 1'b0, "R6");
    wait_n(2);
    pin[3] = 1'b1;
    push(1, 3, 1'b1, 1'b0, "R6");
    push(2, 3, 1'b0, 1'b0, "R6");
    wait_n(3);

    // R10: level mode discards pending edge request
    pin[1] = 1'b0;
    wait_n(4);
    push(0, 1, 1'b1, 1'b0, "R10");
    pin[1] = 1'b1;
    wait_n(4);
    sense[3:2] = 2'b00;
    push(0, 1, 1'b0, 1'b0, "R10");
    tick();
    sense[3:2] = 2'b10;
    push(0, 1, 1'b0, 1'b0, "R10");
    push(3, 1, 1'b0, 1'b0, "R10");
    wait_n(5);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule